// File: doc/BRIEF.md
# Condition Enable and Flag Control Register

This block keeps eight processor condition flags, a matching enable mask for each flag and a 3-bit interrupt channel number. Software changes it through a single write port. Each write word carries four independent command bits: set enables, clear enables, clear flags and set flags. All four act on the same 8-bit condition mask field. Every write also loads a new channel number. The read port returns one packed word: the enables in the upper half, and the flags and the channel in the lower half.

Other logic raises individual flags through a per-condition set input. A timer, for example, drives condition 1. While any flag and its enable are both set, the block raises one request line, the one for the assigned channel. Channel 0 means no request.

Writes that update flags always clear the console-attention condition (condition 6) in the same step. Software therefore never leaves that condition pending by accident.

Top module: `cond_ctl_reg`

## Requirements
- R1: After reset the enables, the flags and the channel are all zero, `rd_data_o` reads 0 and `irq_o` is 0.
- R2: Every write loads the channel from `wr_data_i[2:0]`. The new value is visible from the cycle after the write.
- R3: The condition mask is `wr_data_i[11:4]`, with condition i at bit 4+i. When bit 15 is 1, the mask is ORed into the enables.
- R4: When bit 14 is 1, the masked enables are cleared. This is applied after bit 15, so a write with both bits set leaves the masked enables cleared.
- R5: When bit 13 is 1, the masked flags are cleared. When bit 12 is 1, the masked flags are then set, so a write with both bits set leaves the masked flags set.
- R6: A write with neither bit 12 nor bit 13 set leaves the flags unchanged, whatever its mask.
- R7: A write with bit 12 or bit 13 set leaves condition 6 cleared, whether or not condition 6 is in its mask.
- R8: `rd_data_o` carries the enables in bits 29:22, the flags in bits 11:4 and the channel in bits 2:0. All other bits are zero. Write data bits outside 15:11..4 and 2:0 have no effect.
- R9: A 1 on `cond_set_i[i]` sets flag i in the next cycle. The timer uses condition 1, at read bit 5. This set is applied after a write's flag clear and after the condition-6 auto-clear, so it wins over both.
- R10: `irq_o[c]` is 1 only when the channel equals c, c is not 0, and some flag is set together with its enable. In every other case `irq_o` is all zero.
- R11: Without a write, the enables and the channel keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 36 | Write word: channel, mask and command bits |
| cond_set_i | input | 8 | Per-condition flag set from other blocks |
| rd_data_o | output | 36 | Packed enables, flags and channel |
| irq_o | output | 8 | One-hot interrupt request by channel; bit 0 is never driven high |

## Verification
The bench drives writes that carry both enable commands together and both flag commands together. A design that applies the commands in the wrong order would leave the enables set, or the flags cleared, after such a write. It also makes mask-only writes that carry no flag command; a design that rewrote the flags anyway would lose flags or clear condition 6 when it should not. The bench raises a flag from `cond_set_i` in the same cycle as a clearing write, and it raises condition 6 externally: a design that puts the external set at the wrong priority drops those flags. It also moves the channel to 0 while a request is active, where a wrong encoder would keep a request line high.

// File: rtl/cond_ctl_pkg.sv
package cond_ctl_pkg;
  parameter int DATA_W      = 36;
  parameter int NCOND       = 8;
  parameter int CHAN_W      = 3;
  parameter int COND_LSB    = 4;
  parameter int BIT_FL_SET  = 12;
  parameter int BIT_FL_CLR  = 13;
  parameter int BIT_EN_CLR  = 14;
  parameter int BIT_EN_SET  = 15;
  parameter int RD_EN_LSB   = 22;
  parameter int TIMER_IDX   = 1;
  parameter int CONSOLE_IDX = 6;
  localparam int NCHAN      = 1 << CHAN_W;

  typedef struct packed {
    logic              en_set;
    logic              en_clr;
    logic              fl_clr;
    logic              fl_set;
    logic [NCOND-1:0]  mask;
    logic [CHAN_W-1:0] chan;
  } wr_cmd_t;
endpackage

// File: rtl/cond_ctl_decode.sv
module cond_ctl_decode
  import cond_ctl_pkg::*;
(
  input  logic [DATA_W-1:0] wr_data_i,
  output wr_cmd_t           cmd_o
);
  localparam int COND_MSB = COND_LSB + NCOND - 1;

  logic unused_bits;
  assign unused_bits = ^{wr_data_i[DATA_W-1:BIT_EN_SET+1],
                         wr_data_i[COND_LSB-1:CHAN_W]};

  always_comb begin
    cmd_o.en_set = wr_data_i[BIT_EN_SET];
    cmd_o.en_clr = wr_data_i[BIT_EN_CLR];
    cmd_o.fl_clr = wr_data_i[BIT_FL_CLR];
    cmd_o.fl_set = wr_data_i[BIT_FL_SET];
    cmd_o.mask   = wr_data_i[COND_MSB:COND_LSB];
    cmd_o.chan   = wr_data_i[CHAN_W-1:0];
  end
endmodule

// File: rtl/cond_ctl_state.sv
module cond_ctl_state
  import cond_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  wr_cmd_t           cmd_i,
  input  logic [NCOND-1:0]  cond_set_i,
  output logic [NCOND-1:0]  en_q_o,
  output logic [NCOND-1:0]  fl_q_o,
  output logic [CHAN_W-1:0] chan_q_o
);
  logic [NCOND-1:0]  en_d, fl_d;
  logic [CHAN_W-1:0] chan_d;
  logic              fl_upd;
  logic [NCOND-1:0]  wr_mask;
  logic [CHAN_W-1:0] wr_chan;

  assign fl_upd  = wr_en_i && (cmd_i.fl_clr || cmd_i.fl_set);
  assign wr_mask = cmd_i.mask;
  assign wr_chan = cmd_i.chan;

  always_comb begin
    en_d   = en_q_o;
    fl_d   = fl_q_o;
    chan_d = chan_q_o;
    if (wr_en_i) begin
      chan_d = wr_chan;
      // set then clear: clear wins
      if (cmd_i.en_set) en_d = en_d | wr_mask;
      if (cmd_i.en_clr) en_d = en_d & ~wr_mask;
      if (fl_upd) begin
        if (cmd_i.fl_clr) fl_d = fl_d & ~wr_mask;
        if (cmd_i.fl_set) fl_d = fl_d | wr_mask;
        fl_d[CONSOLE_IDX] = 1'b0;
      end
    end
    // external raise lands last
    fl_d = fl_d | cond_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q_o   <= '0;
      fl_q_o   <= '0;
      chan_q_o <= '0;
    end else begin
      en_q_o   <= en_d;
      fl_q_o   <= fl_d;
      chan_q_o <= chan_d;
    end
  end

  a_r2_chan_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> chan_q_o == $past(wr_chan));
  a_r4_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && cmd_i.en_clr) |=> ((en_q_o & $past(wr_mask)) == '0));
  a_r6_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fl_upd && cond_set_i == '0) |=> $stable(fl_q_o));
  a_r7_console_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_upd && !cond_set_i[CONSOLE_IDX]) |=> !fl_q_o[CONSOLE_IDX]);
  a_r9_ext_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_set_i != '0) |=> ((fl_q_o & $past(cond_set_i)) == $past(cond_set_i)));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(en_q_o) && $stable(chan_q_o)));
endmodule

// File: rtl/cond_ctl_irq.sv
module cond_ctl_irq
  import cond_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCOND-1:0]  en_i,
  input  logic [NCOND-1:0]  fl_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic [NCHAN-1:0]  irq_o
);
  logic pending;
  assign pending = |(en_i & fl_i);

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    if (c == 0) begin : g_none
      assign irq_o[c] = 1'b0;
    end else begin : g_req
      assign irq_o[c] = pending && (chan_i == CHAN_W'(c));
    end
  end

  a_r10_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  a_r10_chan_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_i == '0) |-> (irq_o == '0));
endmodule

// File: rtl/cond_ctl_reg.sv
module cond_ctl_reg
  import cond_ctl_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [NCOND-1:0]        cond_set_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic [(1<<CHAN_W)-1:0]  irq_o
);
  wr_cmd_t           cmd;
  logic [NCOND-1:0]  en_q, fl_q;
  logic [CHAN_W-1:0] chan_q;

  cond_ctl_decode u_dec (
    .wr_data_i (wr_data_i),
    .cmd_o     (cmd)
  );

  cond_ctl_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .cmd_i      (cmd),
    .cond_set_i (cond_set_i),
    .en_q_o     (en_q),
    .fl_q_o     (fl_q),
    .chan_q_o   (chan_q)
  );

  cond_ctl_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_q),
    .fl_i   (fl_q),
    .chan_i (chan_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    rd_data_o                         = '0;
    rd_data_o[RD_EN_LSB +: NCOND]     = en_q;
    rd_data_o[COND_LSB +: NCOND]      = fl_q;
    rd_data_o[CHAN_W-1:0]             = chan_q;
  end

  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> (irq_o == '0));
  a_r8_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[DATA_W-1:RD_EN_LSB+NCOND] == '0) && (rd_data_o[COND_LSB-1:CHAN_W] == '0));
endmodule

// File: tb/cond_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module cond_ctl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [35:0] wr_data = '0;
  logic [7:0]  cond_set = '0;
  logic [35:0] rd_data;
  logic [7:0]  irq;

  always #2.5 clk = ~clk;

  cond_ctl_reg dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .cond_set_i (cond_set),
    .rd_data_o  (rd_data),
    .irq_o      (irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_en = '0, m_fl = '0;
  logic [2:0] m_ch = '0;

  logic [35:0] exp_rd_q[$];
  logic [7:0]  exp_irq_q[$];
  string       tag_q[$];

  task automatic check(string tag, string what, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [35:0] exp_rd();
    logic [35:0] r = '0;
    r[29:22] = m_en;
    r[11:4]  = m_fl;
    r[2:0]   = m_ch;
    return r;
  endfunction

  function automatic logic [7:0] exp_irq();
    if (m_ch != 3'd0 && (m_en & m_fl) != 8'h00) return 8'h01 << m_ch;
    return 8'h00;
  endfunction

  // driver: one cycle of stimulus, model update, expected item pushed
  task automatic step(bit wr, logic [35:0] d, logic [7:0] set, string tag);
    logic [7:0] mask;
    logic [7:0] f;
    @(negedge clk);
    wr_en = wr; wr_data = d; cond_set = set;
    if (wr) begin
      mask = d[11:4];
      m_ch = d[2:0];
      if (d[15]) m_en = m_en | mask;
      if (d[14]) m_en = m_en & ~mask;
      if (d[13] || d[12]) begin
        f = m_fl;
        if (d[13]) f = f & ~mask;
        if (d[12]) f = f | mask;
        f[6] = 1'b0;
        m_fl = f;
      end
    end
    m_fl = m_fl | set;
    @(posedge clk);
    #1;
    exp_rd_q.push_back(exp_rd());
    exp_irq_q.push_back(exp_irq());
    tag_q.push_back(tag);
  endtask

  function automatic logic [35:0] wd(bit es, bit ec, bit fc, bit fs, logic [7:0] m, logic [2:0] ch);
    logic [35:0] r = '0;
    r[15] = es; r[14] = ec; r[13] = fc; r[12] = fs;
    r[11:4] = m; r[2:0] = ch;
    return r;
  endfunction

  // monitor: compares outputs against the scoreboard
  always @(negedge clk) begin
    if (exp_rd_q.size() > 0) begin
      string t;
      logic [35:0] er;
      logic [7:0]  ei;
      t  = tag_q.pop_front();
      er = exp_rd_q.pop_front();
      ei = exp_irq_q.pop_front();
      check(t, "rd_data", rd_data, er);
      check(t, "irq", {28'h0, irq}, {28'h0, ei});
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    check("R1", "rd_data in reset", rd_data, 36'h0);
    check("R1", "irq in reset", {28'h0, irq}, 36'h0);
    rst_ni = 1'b1;
    step(0, '0, 8'h00, "R1");
    step(1, wd(1,0,0,0,8'hFF,3'd5), 8'h00, "R3");            // enable all, ch5
    step(1, wd(0,1,0,0,8'h0F,3'd3), 8'h00, "R4");            // clear low enables, ch3 (R2)
    step(1, wd(1,1,0,0,8'h30,3'd3), 8'h00, "R4");            // both: cleared
    step(1, wd(0,0,0,1,8'hFF,3'd3), 8'h00, "R7");            // set all flags, cond6 auto-cleared
    step(1, wd(0,0,0,0,8'h0F,3'd4), 8'h00, "R6");            // mask only: flags hold
    step(1, wd(0,0,1,0,8'hFF,3'd4), 8'h00, "R5");            // clear all flags
    step(1, wd(0,0,1,1,8'h01,3'd4), 8'h00, "R5");            // clear+set: set
    step(0, '0, 8'h02, "R9");                                // timer cond1
    step(1, wd(1,0,0,0,8'h02,3'd2), 8'h00, "R10");           // irq on ch2
    step(0, '0, 8'h00, "R11");                               // hold
    step(1, wd(0,0,0,0,8'h00,3'd0), 8'h00, "R10");           // ch0: no request
    step(1, wd(0,0,0,0,8'h00,3'd7), 8'h00, "R2");            // ch7 request
    step(1, wd(0,0,1,0,8'h02,3'd7), 8'h02, "R9");            // ext set beats clear
    step(0, '0, 8'h40, "R9");                                // ext console set sticks
    step(1, wd(0,0,0,0,8'hFF,3'd7), 8'h00, "R6");            // console kept by mask-only write
    step(1, wd(0,0,0,1,8'h01,3'd7), 8'h00, "R7");            // flag write clears cond6
    step(1, 36'hF_FFFF_0008 | wd(0,0,0,0,8'h00,3'd1), 8'h00, "R8"); // stray bits ignored
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 48; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[7], {lfsr[3:0], lfsr}, (lfsr[20:18] == 3'b0) ? lfsr[31:24] : 8'h00, "R8");
    end
    step(0, '0, 8'h00, "R11");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule